// File: doc/BRIEF.md
# Program Counter Vectoring Unit

This block holds the 11-bit program counter that addresses a 2048-byte on-chip program store. Each fetch strobe moves the counter forward by one. When the counter passes the top of the store it wraps to zero, because there is no addressing beyond the internal store. A load strobe replaces the counter with a jump target or a return address from the core. A flag sent with the load marks it as the return from an interrupt routine.

Two interrupt sources are served at instruction boundaries, which are opcode fetches. The first is an external request, which is level sensitive. The second is a timer overflow, which is a pulse that the block latches as pending. When an interrupt is taken, the opcode fetch is replaced by a jump to that source's fixed vector. In the same cycle the block raises a push strobe that carries the current counter value, so that an external stack can save it as the return address. After reset the first fetch comes from address 0.

Top module: `pcv_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `fetch_addr` is 0.
- R2: A cycle with `fetch` high, `ld_stb` low and no interrupt taken advances `fetch_addr` by exactly one on the next clock. Without `fetch` and `ld_stb`, `fetch_addr` holds its value.
- R3: When `fetch_addr` is 2047, an advance makes it 0.
- R4: When `ld_stb` is high, `ld_addr` appears on `fetch_addr` at the next clock. This applies even if `fetch` is high in the same cycle. No interrupt is taken in a load cycle.
- R5: An instruction boundary is a cycle with `fetch` and `opc` high and `ld_stb` low. At a boundary where `ext_req` and `ext_en` are both high and no routine is in service, `push_stb` is 1 in that cycle and `push_addr` equals the current `fetch_addr`. On the next clock `fetch_addr` becomes 3.
- R6: A one-cycle `tmr_ovf` pulse sets a pending flag. At a boundary where the flag is set, `tmr_en` is high and no routine is in service, the block pushes as in R5 and `fetch_addr` becomes 7. Taking this vector clears the flag.
- R7: If both sources qualify at the same boundary, the external request wins. The timer flag stays pending and is taken at the first boundary after the service ends.
- R8: Once a vector has been taken, no further interrupt is taken until a cycle with `ld_stb` and `ld_reti` both high.
- R9: While an enable is low, its source takes no vector and the counter advances normally. A pending timer flag is kept while `tmr_en` is low and is taken once `tmr_en` is high.
- R10: A fetch with `opc` low is not a boundary. It advances the counter even when an enabled request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch | input | 1 | Fetch strobe; advances the counter |
| opc | input | 1 | The current fetch is an opcode (instruction boundary) |
| ld_stb | input | 1 | Load the counter from `ld_addr` |
| ld_addr | input | 11 | Jump target or return address |
| ld_reti | input | 1 | With `ld_stb`, ends interrupt service |
| ext_req | input | 1 | External interrupt request, level |
| ext_en | input | 1 | External interrupt enable |
| tmr_ovf | input | 1 | Timer overflow pulse |
| tmr_en | input | 1 | Timer interrupt enable |
| fetch_addr | output | 11 | Program store address |
| push_stb | output | 1 | Save `push_addr` on the stack this cycle |
| push_addr | output | 11 | Return address to save |

## Verification
Two events can fall in the same cycle: a load strobe and an opcode fetch, and the two interrupt sources at one boundary. The bench forces both cases directly. It raises `ld_stb` together with `fetch`, `opc` and an enabled request, and it presents a pending timer flag at the boundary where the external request is high. A behavioural model then judges the outcome on every clock. It checks that the load wins with no push. It checks that the external vector comes first and that the timer vector follows only after the return strobe. A long random phase then mixes all inputs against the same model.

// File: rtl/pcv_pkg.sv
`timescale 1ns/1ps
package pcv_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_EXT  = 2'd1,
      SEL_TMR  = 2'd2
   } vec_sel_e;
endpackage

// File: rtl/pcv_irq_arb.sv
`timescale 1ns/1ps
module pcv_irq_arb
   import pcv_pkg::*;
#(
   parameter bit EXT_FIRST = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     boundary,
   input  logic     reti,
   input  logic     ext_req,
   input  logic     ext_en,
   input  logic     tmr_ovf,
   input  logic     tmr_en,
   output vec_sel_e sel
);
   logic tmr_pend;
   logic in_svc;
   logic ext_ok;
   logic tmr_ok;
   logic gate;
   vec_sel_e pick;

   assign ext_ok = ext_req & ext_en;
   assign tmr_ok = tmr_pend & tmr_en;
   assign gate   = boundary & ~in_svc;

   generate
      if (EXT_FIRST) begin : g_ext_first
         always_comb begin
            if (ext_ok)      pick = SEL_EXT;
            else if (tmr_ok) pick = SEL_TMR;
            else             pick = SEL_NONE;
         end
      end else begin : g_tmr_first
         always_comb begin
            if (tmr_ok)      pick = SEL_TMR;
            else if (ext_ok) pick = SEL_EXT;
            else             pick = SEL_NONE;
         end
      end
   endgenerate

   assign sel = gate ? pick : SEL_NONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_pend <= 1'b0;
         in_svc   <= 1'b0;
      end else begin
         tmr_pend <= (tmr_pend & (sel != SEL_TMR)) | tmr_ovf;
         if (sel != SEL_NONE) in_svc <= 1'b1;
         else if (reti)       in_svc <= 1'b0;
      end
   end
endmodule

// File: rtl/pcv_pc_reg.sv
`timescale 1ns/1ps
module pcv_pc_reg
   import pcv_pkg::*;
#(
   parameter int ADDR_W  = 11,
   parameter int VEC_RST = 0,
   parameter int VEC_EXT = 3,
   parameter int VEC_TMR = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              inc,
   input  vec_sel_e          sel,
   output logic [ADDR_W-1:0] pc
);
   localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(VEC_RST);
   localparam logic [ADDR_W-1:0] A_EXT = ADDR_W'(VEC_EXT);
   localparam logic [ADDR_W-1:0] A_TMR = ADDR_W'(VEC_TMR);
   localparam logic [ADDR_W-1:0] ONE   = ADDR_W'(1);

   logic [ADDR_W-1:0] pc_nxt;

   always_comb begin
      pc_nxt = pc;
      if (ld)                  pc_nxt = ld_addr;
      else if (sel == SEL_EXT) pc_nxt = A_EXT;
      else if (sel == SEL_TMR) pc_nxt = A_TMR;
      else if (inc)            pc_nxt = pc + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= A_RST;
      else        pc <= pc_nxt;
   end
endmodule

// File: rtl/pcv_unit.sv
`timescale 1ns/1ps
module pcv_unit
   import pcv_pkg::*;
#(
   parameter int ADDR_W    = 11,
   parameter int VEC_RST   = 0,
   parameter int VEC_EXT   = 3,
   parameter int VEC_TMR   = 7,
   parameter bit EXT_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch,
   input  logic              opc,
   input  logic              ld_stb,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              ld_reti,
   input  logic              ext_req,
   input  logic              ext_en,
   input  logic              tmr_ovf,
   input  logic              tmr_en,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic              push_stb,
   output logic [ADDR_W-1:0] push_addr
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 3 || ADDR_W > 16) begin : g_bad_width
      $error("pcv_unit: ADDR_W out of range");
   end
   if (VEC_RST >= DEPTH || VEC_EXT >= DEPTH || VEC_TMR >= DEPTH) begin : g_bad_vec
      $error("pcv_unit: vector beyond program store");
   end
   if (VEC_EXT == VEC_TMR) begin : g_same_vec
      $error("pcv_unit: interrupt vectors must differ");
   end

   logic     boundary;
   vec_sel_e sel;
   logic [ADDR_W-1:0] pc;

   assign boundary = fetch & opc & ~ld_stb;

   pcv_irq_arb #(.EXT_FIRST(EXT_FIRST)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .boundary (boundary),
      .reti     (ld_stb & ld_reti),
      .ext_req  (ext_req),
      .ext_en   (ext_en),
      .tmr_ovf  (tmr_ovf),
      .tmr_en   (tmr_en),
      .sel      (sel)
   );

   pcv_pc_reg #(
      .ADDR_W  (ADDR_W),
      .VEC_RST (VEC_RST),
      .VEC_EXT (VEC_EXT),
      .VEC_TMR (VEC_TMR)
   ) u_pc (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (ld_stb),
      .ld_addr (ld_addr),
      .inc     (fetch),
      .sel     (sel),
      .pc      (pc)
   );

   assign fetch_addr = pc;
   assign push_stb   = (sel != SEL_NONE);
   assign push_addr  = pc;
endmodule

// File: rtl/pcv_unit_chk.sv
`timescale 1ns/1ps
module pcv_unit_chk #(
   parameter int ADDR_W  = 11,
   parameter int VEC_EXT = 3,
   parameter int VEC_TMR = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch,
   input logic              opc,
   input logic              ld_stb,
   input logic [ADDR_W-1:0] ld_addr,
   input logic [ADDR_W-1:0] fetch_addr,
   input logic              push_stb
);
   p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb |=> fetch_addr == $past(ld_addr));

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch && !ld_stb && !push_stb) |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch && !ld_stb) |=> $stable(fetch_addr));

   p_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
      push_stb |=> (fetch_addr == ADDR_W'(VEC_EXT) || fetch_addr == ADDR_W'(VEC_TMR)));

   p_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
      push_stb |-> (fetch && opc && !ld_stb));

   p_no_nest_r8: assert property (@(posedge clk) disable iff (!rst_n)
      push_stb |=> !push_stb);
endmodule

bind pcv_unit pcv_unit_chk #(
   .ADDR_W  (ADDR_W),
   .VEC_EXT (VEC_EXT),
   .VEC_TMR (VEC_TMR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fetch      (fetch),
   .opc        (opc),
   .ld_stb     (ld_stb),
   .ld_addr    (ld_addr),
   .fetch_addr (fetch_addr),
   .push_stb   (push_stb)
);

// File: tb/sim_pcv_unit.sv
`timescale 1ns/1ps
module sim_pcv_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fetch = 0, opc = 0, ld_stb = 0, ld_reti = 0;
   logic ext_req = 0, ext_en = 0, tmr_ovf = 0, tmr_en = 0;
   logic [10:0] ld_addr = '0;
   logic [10:0] fetch_addr, push_addr;
   logic push_stb;

   int checks = 0;
   int errors = 0;
   int m_pc = 0;
   bit m_svc = 0;
   bit m_pend = 0;

   always #4 clk = ~clk;

   pcv_unit u0 (
      .clk(clk), .rst_n(rst_n), .fetch(fetch), .opc(opc), .ld_stb(ld_stb),
      .ld_addr(ld_addr), .ld_reti(ld_reti), .ext_req(ext_req), .ext_en(ext_en),
      .tmr_ovf(tmr_ovf), .tmr_en(tmr_en), .fetch_addr(fetch_addr),
      .push_stb(push_stb), .push_addr(push_addr)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic set_in(input bit f, input bit o, input bit l, input int a, input bit r,
                         input bit er, input bit ee, input bit tv, input bit te);
      fetch = f; opc = o; ld_stb = l; ld_addr = 11'(a); ld_reti = r;
      ext_req = er; ext_en = ee; tmr_ovf = tv; tmr_en = te;
   endtask

   // one cycle: inputs already driven after a negedge; compare, then advance model
   task automatic cyc(input string tag);
      bit bnd, ok_e, ok_t, take, is_e;
      #1;
      bnd  = fetch && opc && !ld_stb;
      ok_e = ext_req && ext_en;
      ok_t = m_pend && tmr_en;
      take = bnd && !m_svc && (ok_e || ok_t);
      is_e = ok_e;
      chk(tag, int'(fetch_addr), m_pc);
      chk(tag, int'(push_stb), int'(take));
      if (take) chk(tag, int'(push_addr), m_pc);
      @(posedge clk);
      if (ld_stb) begin
         m_pc = int'(ld_addr);
         if (ld_reti) m_svc = 0;
      end else if (take) begin
         m_pc = is_e ? 3 : 7;
         m_svc = 1;
      end else if (fetch) m_pc = (m_pc + 1) % 2048;
      m_pend = (m_pend && !(take && !is_e)) || tmr_ovf;
      @(negedge clk);
   endtask

   initial begin
      #1600000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      repeat (2) begin
         #1; chk("R1", int'(fetch_addr), 0);
         @(negedge clk);
      end
      rst_n = 1'b1;
      // R1: first cycle after release
      set_in(0,0,0,0,0,0,0,0,0); cyc("R1");
      // R2: plain fetches and holds
      for (int i = 0; i < 5; i++) begin set_in(1,1,0,0,0,0,0,0,0); cyc("R2"); end
      set_in(0,0,0,0,0,0,0,0,0); cyc("R2"); cyc("R2");
      // R4 then R3 wrap
      set_in(0,0,1,2046,0,0,0,0,0); cyc("R4");
      for (int i = 0; i < 3; i++) begin set_in(1,1,0,0,0,0,0,0,0); cyc("R3"); end
      // R4: load collides with opcode fetch and an enabled request
      set_in(1,1,1,100,0,1,1,0,0); cyc("R4"); cyc("R4");
      // R10: non-opcode fetch with enabled request
      set_in(1,0,0,0,0,1,1,0,0); cyc("R10"); cyc("R10");
      // R5: take external vector
      set_in(1,1,0,0,0,1,1,0,0); cyc("R5"); chk("R5", int'(fetch_addr), 3);
      // R8: blocked while in service, timer pulse arrives
      set_in(1,1,0,0,0,1,1,1,1); cyc("R8");
      set_in(1,1,0,0,0,1,1,0,1); cyc("R8"); cyc("R8");
      // R7: return, then both qualify -> external wins
      set_in(0,0,1,200,1,0,0,0,1); cyc("R7");
      set_in(1,1,0,0,0,1,1,0,1); cyc("R7"); chk("R7", int'(fetch_addr), 3);
      set_in(0,0,1,300,1,0,1,0,1); cyc("R7");
      set_in(1,1,0,0,0,0,1,0,1); cyc("R7"); chk("R7", int'(fetch_addr), 7);
      // R6: flag cleared after timer vector
      set_in(0,0,1,400,1,0,0,0,1); cyc("R6");
      set_in(1,1,0,0,0,0,0,0,1); cyc("R6"); chk("R6", int'(fetch_addr), 401);
      // R9: disabled sources, pending kept
      set_in(1,1,0,0,0,1,0,1,0); cyc("R9");
      set_in(1,1,0,0,0,1,0,0,0); cyc("R9"); cyc("R9");
      set_in(1,1,0,0,0,0,0,0,1); cyc("R9"); chk("R9", int'(fetch_addr), 7);
      // random mix against model
      for (int i = 0; i < 3000; i++) begin
         bit l = ($urandom % 8) == 0;
         set_in(($urandom % 4) != 0, ($urandom % 2) != 0, l, int'($urandom % 2048),
                ($urandom % 2) != 0, ($urandom % 6) == 0, ($urandom % 3) != 0,
                ($urandom % 10) == 0, ($urandom % 3) != 0);
         cyc(l ? "R4" : "R2");
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule